// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a very small processor. It has one working register (the accumulator), a program counter and an instruction register. It runs a fixed fetch, capture and execute loop against one byte-wide memory port. Code and data share that port and one address space, so a store can overwrite a byte that the core fetches later as an instruction. Memory reads are synchronous: an address driven in one cycle returns its data in the next cycle.

The instruction set has three one-byte opcodes and no operand bytes. Increment adds one to the accumulator. Decrement subtracts one. Store writes the accumulator to the address given by the bitwise complement of the accumulator. Any other byte stops the core. It then raises a halted flag and stays frozen until reset.

The reset value of the program counter comes from an input pin, so one build can run programs placed anywhere in the 256-byte space.

Top module: `tac_core`

## Requirements
- R1: While reset is low and on leaving reset, the accumulator is zero, the program counter equals `pc_init`, `mem_addr` shows `pc_init`, `mem_we` is 0 and `halted` is 0. This holds even when reset is applied in the middle of a program or while halted.
- R2: Each instruction takes exactly three clock cycles. In the first cycle the program counter is driven on `mem_addr`. In the second the returned byte is latched and the counter advances by one. In the third the instruction executes. A program of N instructions that ends on an undefined opcode raises `halted` 3·N cycles after reset is released.
- R3: Opcode 0xF0 adds one to the accumulator, wrapping from 0xFF to 0x00.
- R4: Opcode 0xF2 subtracts one from the accumulator, wrapping from 0x00 to 0xFF.
- R5: Opcode 0x5F drives `mem_we` high for exactly one cycle. In that cycle `mem_wdata` is the accumulator and `mem_addr` is its bitwise complement.
- R6: Increment and decrement never assert `mem_we`. A program writes memory exactly once per store it executes.
- R7: The program counter wraps from 0xFF to 0x00, so code may run across the top of the address space.
- R8: Any opcode other than 0xF0, 0xF2 and 0x5F sets `halted`. From then until reset, `mem_we` stays 0 and `mem_addr` stays at the address after the offending byte.
- R9: A store into a byte that has not yet been fetched changes the instruction the core later executes there.
- R10: Start with the accumulator at 0xF2 and the program counter at 0x80, with 0xF0 at 0x80 and 0x5F at 0x81. After these two instructions the accumulator is 0xF3, memory byte 0x0C holds 0xF3, and the next fetch is from 0x82.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_init | input | 8 | Value loaded into the program counter during reset |
| mem_addr | output | 8 | Memory address: fetch address, or store address during a store |
| mem_wdata | output | 8 | Store data (the accumulator) |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | High once an undefined opcode has executed |

## Verification
The assertions assume that `mem_rdata` follows a memory with one cycle of read latency. They also assume that `pc_init` is only sampled while reset is low, so a change of `pc_init` outside reset has no effect to check. The bench memory model registers its read data on every edge and applies writes on the same edge. The bench changes `pc_init` only while it holds reset low. Every program it loads ends on an undefined byte, so each run stops in the halted state that the hold checks rely on.

// File: rtl/tac_pkg.sv
package tac_pkg;

   // Sequencer phases; one instruction visits REQ, CAP, EXE in that order.
   typedef enum logic [1:0] {
      PH_REQ  = 2'd0,
      PH_CAP  = 2'd1,
      PH_EXE  = 2'd2,
      PH_STOP = 2'd3
   } tac_phase_e;

   // Decoded operation class.
   typedef enum logic [1:0] {
      OPK_INC   = 2'd0,
      OPK_DEC   = 2'd1,
      OPK_STORE = 2'd2,
      OPK_BAD   = 2'd3
   } tac_kind_e;

endpackage

// File: rtl/tac_decode.sv
module tac_decode
   import tac_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] OP_INC   = 'hF0,
   parameter logic [W-1:0] OP_DEC   = 'hF2,
   parameter logic [W-1:0] OP_STORE = 'h5F
) (
   input  logic [W-1:0] ir,
   output tac_kind_e    kind
);

   always_comb begin
      if (ir == OP_INC)
         kind = OPK_INC;
      else if (ir == OP_DEC)
         kind = OPK_DEC;
      else if (ir == OP_STORE)
         kind = OPK_STORE;
      else
         kind = OPK_BAD;
   end

endmodule

// File: rtl/tac_alu.sv
module tac_alu
   import tac_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  tac_kind_e    kind,
   input  logic [W-1:0] acc,
   output logic [W-1:0] acc_nxt,
   output logic         wr_req,
   output logic [W-1:0] wr_addr
);

   localparam logic [W-1:0] ONE = W'(1);

   // The store address is formed from the accumulator itself.
   assign wr_addr = ~acc;

   always_comb begin
      acc_nxt = acc;
      wr_req  = 1'b0;
      unique case (kind)
         OPK_INC:   acc_nxt = acc + ONE;
         OPK_DEC:   acc_nxt = acc - ONE;
         OPK_STORE: wr_req  = 1'b1;
         default:   acc_nxt = acc;
      endcase
   end

endmodule

// File: rtl/tac_seq.sv
module tac_seq
   import tac_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  tac_kind_e  kind,
   output tac_phase_e phase
);

   tac_phase_e phase_nxt;

   always_comb begin
      unique case (phase)
         PH_REQ:  phase_nxt = PH_CAP;
         PH_CAP:  phase_nxt = PH_EXE;
         PH_EXE:  phase_nxt = (kind == OPK_BAD) ? PH_STOP : PH_REQ;
         default: phase_nxt = PH_STOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= PH_REQ;
      else
         phase <= phase_nxt;
   end

endmodule

// File: rtl/tac_core.sv
module tac_core
   import tac_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] OP_INC   = 'hF0,
   parameter logic [W-1:0] OP_DEC   = 'hF2,
   parameter logic [W-1:0] OP_STORE = 'h5F
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pc_init,
   output logic [W-1:0] mem_addr,
   output logic [W-1:0] mem_wdata,
   output logic         mem_we,
   input  logic [W-1:0] mem_rdata,
   output logic         halted
);

   localparam logic [W-1:0] PC_STEP = W'(1);

   generate
      if (W < 2) begin : g_w_chk
         $error("tac_core: W must be at least 2");
      end
      if (OP_INC == OP_DEC || OP_INC == OP_STORE || OP_DEC == OP_STORE) begin : g_op_chk
         $error("tac_core: opcodes must be distinct");
      end
   endgenerate

   logic [W-1:0] pc_q;
   logic [W-1:0] ir_q;
   logic [W-1:0] acc_q;
   logic [W-1:0] acc_nxt;
   logic [W-1:0] st_addr;
   logic         st_req;
   tac_kind_e    kind;
   tac_phase_e   phase;

   tac_decode #(
      .W(W), .OP_INC(OP_INC), .OP_DEC(OP_DEC), .OP_STORE(OP_STORE)
   ) u_dec (
      .ir   (ir_q),
      .kind (kind)
   );

   tac_alu #(.W(W)) u_alu (
      .kind    (kind),
      .acc     (acc_q),
      .acc_nxt (acc_nxt),
      .wr_req  (st_req),
      .wr_addr (st_addr)
   );

   tac_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .phase (phase)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= pc_init;
         ir_q  <= '0;
         acc_q <= '0;
      end else begin
         unique case (phase)
            PH_CAP: begin
               ir_q <= mem_rdata;
               pc_q <= pc_q + PC_STEP;
            end
            PH_EXE:  acc_q <= acc_nxt;
            default: ;
         endcase
      end
   end

   logic exe_store;
   assign exe_store = (phase == PH_EXE) && st_req;

   assign mem_we    = exe_store;
   assign mem_addr  = exe_store ? st_addr : pc_q;
   assign mem_wdata = acc_q;
   assign halted    = (phase == PH_STOP);

endmodule

// File: rtl/tac_core_chk.sv
module tac_core_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] mem_addr,
   input logic [W-1:0] mem_wdata,
   input logic         mem_we,
   input logic         halted,
   input logic [W-1:0] acc,
   input logic [W-1:0] pc
);

   // R5
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R5
   store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == ~mem_wdata));

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R8
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   // R8
   halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(mem_addr));

   // R3 R4
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc) |-> (acc == W'($past(acc) + W'(1)) || acc == W'($past(acc) - W'(1))));

   // R6
   acc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc) |-> !$past(mem_we));

   // R7
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> (pc == W'($past(pc) + W'(1))));

endmodule

bind tac_core tac_core_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_we    (mem_we),
   .halted    (halted),
   .acc       (acc_q),
   .pc        (pc_q)
);

// File: tb/tb_tac_core.sv
module tb_tac_core;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC = 6;
   // {pc_init, n_inc, n_dec, expected store value}
   localparam logic [31:0] VEC [N_VEC] = '{
      32'h10_00_00_00,
      32'h10_01_00_01,
      32'h20_00_01_FF,
      32'h40_03_01_02,
      32'hFC_04_00_04,
      32'h60_05_03_02
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pc_init = 8'h00;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic       mem_we, halted;

   logic [7:0] mem [256];
   int         wcnt;
   logic [7:0] w_addr, w_data;
   int         checks = 0;
   int         failures = 0;
   int         cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tac_core dut (
      .clk(clk), .rst_n(rst_n), .pc_init(pc_init),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata), .halted(halted)
   );

   always @(posedge clk) begin
      mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (!rst_n) wcnt <= 0;
      else if (mem_we) begin
         wcnt   <= wcnt + 1;
         w_addr <= mem_addr;
         w_data <= mem_wdata;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   // Hold reset two cycles with the given start address, release on a falling edge.
   task automatic do_reset(input logic [7:0] pc);
      @(negedge clk);
      rst_n = 1'b0;
      pc_init = pc;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_halt(output int n);
      n = 0;
      while (!halted && n < 400) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      logic [7:0] pc, ninc, ndec, ev, a;

      clear_mem();
      mem[8'h10] = 8'h5F;
      pc_init = 8'h10;
      repeat (2) @(negedge clk);
      // R1: state during reset
      chk(mem_addr == 8'h10, "R1 reset addr", mem_addr, 8'h10);
      chk(mem_we == 1'b0, "R1 reset we", mem_we, 0);
      chk(halted == 1'b0, "R1 reset halted", halted, 0);

      // Table-driven programs: incs, decs, one store, then an undefined byte.
      for (int v = 0; v < N_VEC; v++) begin
         {pc, ninc, ndec, ev} = VEC[v];
         @(negedge clk);
         rst_n = 1'b0;
         clear_mem();
         a = pc;
         for (int k = 0; k < ninc; k++) begin mem[a] = 8'hF0; a = a + 8'd1; end
         for (int k = 0; k < ndec; k++) begin mem[a] = 8'hF2; a = a + 8'd1; end
         mem[a] = 8'h5F;
         do_reset(pc);
         wait_halt(n);
         chk(n == 3 * (ninc + ndec + 2), "R2 cycles to halt", n, 3 * (ninc + ndec + 2));
         chk(wcnt == 1, "R6 single write", wcnt, 1);
         chk(w_data == ev, "R3/R4 stored value", w_data, ev);
         chk(w_addr == ~ev, "R5 store address", w_addr, ~ev);
         chk(mem_addr == 8'(a + 8'd2), "R7 R8 halt address", mem_addr, 8'(a + 8'd2));
      end

      // R2: fetch addresses at instruction boundaries
      clear_mem();
      for (int k = 0; k < 3; k++) mem[8'h50 + k] = 8'hF0;
      do_reset(8'h50);
      chk(mem_addr == 8'h50, "R2 fetch 0", mem_addr, 8'h50);
      repeat (3) @(negedge clk);
      chk(mem_addr == 8'h51, "R2 fetch 1", mem_addr, 8'h51);
      repeat (3) @(negedge clk);
      chk(mem_addr == 8'h52, "R2 fetch 2", mem_addr, 8'h52);
      wait_halt(n);

      // R3: increment wraps 0xFF -> 0x00
      clear_mem();
      mem[8'h30] = 8'hF2; mem[8'h31] = 8'hF0; mem[8'h32] = 8'h5F;
      do_reset(8'h30);
      wait_halt(n);
      chk(w_data == 8'h00, "R3 wrap data", w_data, 8'h00);
      chk(w_addr == 8'hFF, "R3 wrap addr", w_addr, 8'hFF);

      // R8: halted state holds
      a = mem_addr;
      repeat (6) @(negedge clk);
      chk(halted == 1'b1, "R8 halt sticky", halted, 1);
      chk(mem_addr == a, "R8 addr held", mem_addr, a);
      chk(wcnt == 1, "R8 no write while halted", wcnt, 1);

      // R1: reset out of halt
      @(negedge clk);
      rst_n = 1'b0;
      pc_init = 8'hA5;
      @(negedge clk);
      chk(halted == 1'b0, "R1 halt cleared", halted, 0);
      chk(mem_addr == 8'hA5, "R1 new pc_init", mem_addr, 8'hA5);

      // R1: reset in mid-program, accumulator back at zero
      clear_mem();
      for (int k = 0; k < 4; k++) mem[8'hB0 + k] = 8'hF0;
      mem[8'hC0] = 8'h5F;
      do_reset(8'hB0);
      repeat (7) @(negedge clk);
      do_reset(8'hC0);
      chk(mem_addr == 8'hC0, "R1 mid reset addr", mem_addr, 8'hC0);
      wait_halt(n);
      chk(w_data == 8'h00, "R1 acc cleared", w_data, 8'h00);

      // R9: store rewrites a not-yet-fetched byte (0xF0 at 0xFB becomes 0x04)
      clear_mem();
      for (int k = 0; k < 4; k++) mem[8'hF6 + k] = 8'hF0;
      mem[8'hFA] = 8'h5F;
      mem[8'hFB] = 8'hF0;
      do_reset(8'hF6);
      wait_halt(n);
      chk(mem[8'hFB] == 8'h04, "R9 code byte overwritten", mem[8'hFB], 8'h04);
      chk(mem_addr == 8'hFC, "R9 halted on rewritten byte", mem_addr, 8'hFC);

      // R10: 14 decrements bring acc to 0xF2 with PC at 0x80
      clear_mem();
      for (int k = 0; k < 14; k++) mem[8'h72 + k] = 8'hF2;
      mem[8'h80] = 8'hF0;
      mem[8'h81] = 8'h5F;
      do_reset(8'h72);
      repeat (42) @(negedge clk);
      chk(mem_addr == 8'h80, "R10 pc at 0x80", mem_addr, 8'h80);
      repeat (6) @(negedge clk);
      chk(mem_addr == 8'h82, "R10 next fetch 0x82", mem_addr, 8'h82);
      chk(mem[8'h0C] == 8'hF3, "R10 memory 0x0C", mem[8'h0C], 8'hF3);
      chk(w_data == 8'hF3, "R10 accumulator", w_data, 8'hF3);
      wait_halt(n);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule